// File: doc/BRIEF.md
# Debug Trigger and Breakpoint Controller

This block turns comparator match pulses into debug actions. Each comparator is set to one of two modes. In immediate mode a match counts as a hit on the clock edge where it is seen. In deferred mode a match only marks the instruction that is being fetched. The hit then happens only when the instruction pipeline reports that this instruction has reached execution. If the pipeline discards the instruction first, the mark is dropped.

Hits drive a small sequencer with the states Idle, Stage1, Stage2, Stage3 and Final. Software programs the route through the sequencer. For each of the three stages it picks the comparator that advances that stage and the state to move to. When the sequencer enters Final, it can request a breakpoint, start bus tracing, or both. It also sets a sticky trigger flag. External tag lines, a coprocessor software breakpoint request and a self-clearing software trigger bit also raise breakpoints. These sources do not pass through the sequencer. Secure mode blocks trace start but still lets breakpoints through. Everything is gated by the arm bit.

Top module: `dbg_trig_ctrl`

## Requirements
- R1: While `arm_i` is low, the following all hold. The sequencer returns to Idle (code 0) on the next edge. No hit is produced. Pending deferred marks are cleared. `brk_o` and `trace_start_o` stay low, including for the bypass breakpoint sources.
- R2: If a comparator is in immediate mode (`cmp_defer_i` bit = 0) and matches while armed, this is a hit on that same edge.
- R3: Deferred mode (`cmp_defer_i` bit = 1) works as follows. A match sets a pending mark. The mark produces a hit on the first later edge with `exec_i` high; this holds even if `flush_i` is also high on that edge. `flush_i` without `exec_i` clears the mark with no hit. A match on the same edge as `exec_i` marks the new instruction.
- R4: The sequencer follows these rules. Idle moves to Stage1 on the first armed edge. In Stage N (N = 1..3), a hit on comparator `seq_sel_i[2N-1:2N-2]` moves it to the state coded in `seq_next_i[3N-1:3N-3]`. The codes are 0 Idle, 1 to 3 Stage1 to Stage3, and 4 to 7 Final. Final holds until disarm. `seq_state_o` shows the state code.
- R5: On the edge where the sequencer enters Final, `brk_o` pulses high for one cycle if `fin_brk_en_i` is set, and `trace_start_o` pulses high for one cycle if `fin_trace_en_i` is set.
- R6: If `secure_i` is high on the edge where Final is entered, `trace_start_o` stays low and the breakpoint still occurs.
- R7: While armed, any `ext_tag_i` bit or `cop_brk_i` raises `brk_o` on the next edge. This happens in any sequencer state.
- R8: A write pulse on `sw_trig_wr_i` sets `sw_trig_o` for exactly one cycle. If the block is armed during that cycle, `brk_o` rises on the following edge.
- R9: `trig_flag_o` is set when the sequencer enters Final. It stays set through disarm and clears on the first armed edge after a disarmed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm bit |
| secure_i | input | 1 | Secure mode, suppresses trace start |
| cmp_match_i | input | 4 | Comparator match pulses |
| cmp_defer_i | input | 4 | Per-comparator mode: 1 deferred, 0 immediate |
| exec_i | input | 1 | Marked instruction reached execution |
| flush_i | input | 1 | Marked instruction discarded |
| ext_tag_i | input | 2 | External breakpoint tag lines |
| cop_brk_i | input | 1 | Coprocessor software breakpoint request |
| sw_trig_wr_i | input | 1 | Write of 1 to the software trigger bit |
| seq_sel_i | input | 6 | Comparator select for Stage1..Stage3, 2 bits each |
| seq_next_i | input | 9 | Next-state code for Stage1..Stage3, 3 bits each |
| fin_brk_en_i | input | 1 | Final state requests a breakpoint |
| fin_trace_en_i | input | 1 | Final state starts tracing |
| brk_o | output | 1 | Breakpoint request pulse |
| trace_start_o | output | 1 | Trace start pulse |
| trig_flag_o | output | 1 | Sticky trigger flag |
| sw_trig_o | output | 1 | Software trigger bit |
| seq_state_o | output | 3 | Sequencer state code |

## Verification
The assertions check the following on every cycle:
- disarm forces Idle and silences all hits;
- a flush with no execution leaves no pending mark;
- secure mode never lets a trace start through;
- Final entry with breaks enabled always yields `brk_o`;
- a visible software trigger bit yields a breakpoint;
- the trigger flag holds until re-arm.

Only the bench scenarios can show the complete stage routes, including codes that loop back to Idle and codes above 4. They also show that a discarded deferred instruction never advances the sequencer, that the breakpoint is a single pulse, and the exact cycle offsets of each bypass source.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_ST1   = 3'd1,
    SQ_ST2   = 3'd2,
    SQ_ST3   = 3'd3,
    SQ_FINAL = 3'd4
  } sq_state_e;

  localparam int NUM_STAGES = 3;
  localparam int CODE_W     = 3;

  // Any code at or above the Final code lands in Final.
  function automatic sq_state_e decode_target(logic [CODE_W-1:0] code);
    if (code >= 3'd4) return SQ_FINAL;
    return sq_state_e'(code);
  endfunction

  // One sequencer step.
  function automatic sq_state_e seq_step(sq_state_e cur, logic armed,
                                         logic sel_hit,
                                         logic [CODE_W-1:0] code);
    if (!armed) return SQ_IDLE;
    case (cur)
      SQ_IDLE:  return SQ_ST1;
      SQ_FINAL: return SQ_FINAL;
      default:  return sel_hit ? decode_target(code) : cur;
    endcase
  endfunction

  // Stage index (0..2) for a stage state.
  function automatic int stage_index(sq_state_e cur);
    return int'(cur) - 1;
  endfunction

endpackage

// File: rtl/dbg_tag_unit.sv
module dbg_tag_unit #(
  parameter int NCMP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic [NCMP-1:0] match_i,
  input  logic [NCMP-1:0] defer_i,
  input  logic            exec_i,
  input  logic            flush_i,
  output logic [NCMP-1:0] hit_o
);

  logic [NCMP-1:0] pend_q;

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    logic forced_hit;
    logic deferred_hit;
    logic mark_new;
    logic mark_keep;

    assign forced_hit   = arm_i & match_i[c] & ~defer_i[c];
    assign deferred_hit = arm_i & defer_i[c] & pend_q[c] & exec_i;
    assign mark_new     = arm_i & match_i[c] & defer_i[c];
    assign mark_keep    = pend_q[c] & ~exec_i & ~flush_i;
    assign hit_o[c]     = forced_hit | deferred_hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pend_q[c] <= 1'b0;
      else if (!arm_i) pend_q[c] <= 1'b0;
      else             pend_q[c] <= mark_new | mark_keep;
    end

    AST_FLUSH_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flush_i && !exec_i && !match_i[c]) |=> !pend_q[c]); // R3
  end

  AST_DISARM_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |-> (hit_o == '0)); // R1

endmodule

// File: rtl/dbg_seq.sv
module dbg_seq
  import dbg_trig_pkg::*;
#(
  parameter int NCMP = 4,
  parameter int CW   = $clog2(NCMP)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         arm_i,
  input  logic [NCMP-1:0]              hit_i,
  input  logic [NUM_STAGES*CW-1:0]     sel_i,
  input  logic [NUM_STAGES*CODE_W-1:0] next_i,
  output logic [2:0]                   state_o,
  output logic                         enter_final_o
);

  sq_state_e         state_q, state_d;
  logic [CW-1:0]     cur_sel;
  logic [CODE_W-1:0] cur_code;
  logic              sel_hit;

  always_comb begin
    cur_sel  = '0;
    cur_code = '0;
    if (state_q inside {SQ_ST1, SQ_ST2, SQ_ST3}) begin
      cur_sel  = sel_i[stage_index(state_q)*CW +: CW];
      cur_code = next_i[stage_index(state_q)*CODE_W +: CODE_W];
    end
  end

  assign sel_hit       = hit_i[cur_sel];
  assign state_d       = seq_step(state_q, arm_i, sel_hit, cur_code);
  assign enter_final_o = (state_d == SQ_FINAL) && (state_q != SQ_FINAL);
  assign state_o       = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SQ_IDLE;
    else         state_q <= state_d;
  end

  AST_DISARM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_i |=> (state_o == 3'd0)); // R1

  AST_FINAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && arm_i) |=> (state_o == 3'd4)); // R4

endmodule

// File: rtl/dbg_action.sv
module dbg_action #(
  parameter int NTAG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            arm_i,
  input  logic            secure_i,
  input  logic            enter_final_i,
  input  logic            fin_brk_en_i,
  input  logic            fin_trace_en_i,
  input  logic [NTAG-1:0] ext_tag_i,
  input  logic            cop_brk_i,
  input  logic            sw_trig_wr_i,
  output logic            brk_o,
  output logic            trace_start_o,
  output logic            trig_flag_o,
  output logic            sw_trig_o
);

  logic arm_q;
  logic rearm;
  logic bypass_ev;
  logic final_brk;
  logic final_trace;

  assign rearm       = arm_i & ~arm_q;
  assign bypass_ev   = arm_i & ((|ext_tag_i) | cop_brk_i | sw_trig_o);
  assign final_brk   = arm_i & enter_final_i & fin_brk_en_i;
  assign final_trace = arm_i & enter_final_i & fin_trace_en_i & ~secure_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q         <= 1'b0;
      brk_o         <= 1'b0;
      trace_start_o <= 1'b0;
      trig_flag_o   <= 1'b0;
      sw_trig_o     <= 1'b0;
    end else begin
      arm_q         <= arm_i;
      brk_o         <= final_brk | bypass_ev;
      trace_start_o <= final_trace;
      sw_trig_o     <= sw_trig_wr_i;
      if (rearm)                      trig_flag_o <= 1'b0;
      else if (arm_i && enter_final_i) trig_flag_o <= 1'b1;
    end
  end

  AST_SECURE_NO_TRACE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    secure_i |=> !trace_start_o); // R6

  AST_FINAL_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && enter_final_i && fin_brk_en_i) |=> brk_o); // R5

  AST_SWTRIG_BREAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_trig_o && arm_i) |=> brk_o); // R8

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_flag_o && !rearm) |=> trig_flag_o); // R9

endmodule

// File: rtl/dbg_trig_ctrl.sv
module dbg_trig_ctrl
  import dbg_trig_pkg::*;
#(
  parameter int NCMP = 4,
  parameter int NTAG = 2,
  localparam int CW  = $clog2(NCMP)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         arm_i,
  input  logic                         secure_i,
  input  logic [NCMP-1:0]              cmp_match_i,
  input  logic [NCMP-1:0]              cmp_defer_i,
  input  logic                         exec_i,
  input  logic                         flush_i,
  input  logic [NTAG-1:0]              ext_tag_i,
  input  logic                         cop_brk_i,
  input  logic                         sw_trig_wr_i,
  input  logic [NUM_STAGES*CW-1:0]     seq_sel_i,
  input  logic [NUM_STAGES*CODE_W-1:0] seq_next_i,
  input  logic                         fin_brk_en_i,
  input  logic                         fin_trace_en_i,
  output logic                         brk_o,
  output logic                         trace_start_o,
  output logic                         trig_flag_o,
  output logic                         sw_trig_o,
  output logic [2:0]                   seq_state_o
);

  logic [NCMP-1:0] hit_vec;
  logic            enter_final;

  dbg_tag_unit #(.NCMP(NCMP)) u_tag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .arm_i   (arm_i),
    .match_i (cmp_match_i),
    .defer_i (cmp_defer_i),
    .exec_i  (exec_i),
    .flush_i (flush_i),
    .hit_o   (hit_vec)
  );

  dbg_seq #(.NCMP(NCMP), .CW(CW)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .arm_i         (arm_i),
    .hit_i         (hit_vec),
    .sel_i         (seq_sel_i),
    .next_i        (seq_next_i),
    .state_o       (seq_state_o),
    .enter_final_o (enter_final)
  );

  dbg_action #(.NTAG(NTAG)) u_act (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .arm_i          (arm_i),
    .secure_i       (secure_i),
    .enter_final_i  (enter_final),
    .fin_brk_en_i   (fin_brk_en_i),
    .fin_trace_en_i (fin_trace_en_i),
    .ext_tag_i      (ext_tag_i),
    .cop_brk_i      (cop_brk_i),
    .sw_trig_wr_i   (sw_trig_wr_i),
    .brk_o          (brk_o),
    .trace_start_o  (trace_start_o),
    .trig_flag_o    (trig_flag_o),
    .sw_trig_o      (sw_trig_o)
  );

  AST_FORCED_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && seq_state_o == 3'd1 && cmp_match_i[seq_sel_i[CW-1:0]]
     && !cmp_defer_i[seq_sel_i[CW-1:0]]
     && seq_next_i[CODE_W-1:0] == 3'd2) |=> (seq_state_o == 3'd2)); // R2

endmodule

// File: tb/tb_dbg_trig_ctrl.sv
module tb_dbg_trig_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       arm = 0, secure = 0, exec_p = 0, flush_p = 0, cop = 0, sw_wr = 0;
  logic [3:0] match = '0, defer = '0;
  logic [1:0] ext_tag = '0;
  logic [5:0] sel = '0;
  logic [8:0] nxt = '0;
  logic       brk_en = 0, trace_en = 0;
  logic       brk, trace, flag, swt;
  logic [2:0] st;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_trig_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .arm_i(arm), .secure_i(secure),
    .cmp_match_i(match), .cmp_defer_i(defer), .exec_i(exec_p),
    .flush_i(flush_p), .ext_tag_i(ext_tag), .cop_brk_i(cop),
    .sw_trig_wr_i(sw_wr), .seq_sel_i(sel), .seq_next_i(nxt),
    .fin_brk_en_i(brk_en), .fin_trace_en_i(trace_en),
    .brk_o(brk), .trace_start_o(trace), .trig_flag_o(flag),
    .sw_trig_o(swt), .seq_state_o(st)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference model
  int m_state = 0;
  bit m_pend[4];
  bit m_sw = 0, m_brk = 0, m_trace = 0, m_flag = 0, m_armp = 0;

  always @(posedge clk) begin : model
    bit h[4];
    int target;
    bit enter;
    if (!rst_n) begin
      m_state = 0; m_sw = 0; m_brk = 0; m_trace = 0; m_flag = 0; m_armp = 0;
      for (int c = 0; c < 4; c++) m_pend[c] = 0;
    end else begin
      for (int c = 0; c < 4; c++) begin
        if (!arm) h[c] = 0;
        else if (defer[c]) h[c] = m_pend[c] && exec_p;
        else h[c] = match[c];
      end
      target = m_state;
      if (!arm) target = 0;
      else if (m_state == 0) target = 1;
      else if (m_state >= 1 && m_state <= 3) begin
        if (h[(sel >> (2*(m_state-1))) & 3]) begin
          target = (nxt >> (3*(m_state-1))) & 7;
          if (target > 4) target = 4;
        end
      end
      enter = (target == 4) && (m_state != 4);
      m_brk = (arm && (ext_tag != 0 || cop || m_sw)) || (enter && brk_en);
      m_trace = enter && trace_en && !secure;
      if (arm && !m_armp) m_flag = 0;
      else if (enter) m_flag = 1;
      m_sw = sw_wr;
      for (int c = 0; c < 4; c++)
        m_pend[c] = arm && ((m_pend[c] && !exec_p && !flush_p) || (match[c] && defer[c]));
      m_armp = arm;
      m_state = target;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R5/R7 brk", int'(brk), int'(m_brk));
      chk("R6 trace", int'(trace), int'(m_trace));
      chk("R9 flag", int'(flag), int'(m_flag));
      chk("R8 swbit", int'(swt), int'(m_sw));
      chk("R4 state", int'(st), m_state);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    chk("R1 reset brk", int'(brk), 0);
    chk("R1 reset state", int'(st), 0);
    rst_n = 1;
    tick();

    // R1: disarmed, every source ignored
    ext_tag = 2'b11; match = 4'hF; cop = 1; sw_wr = 1; tick();
    ext_tag = 0; match = 0; cop = 0; sw_wr = 0;
    chk("R1 brk disarmed", int'(brk), 0);
    chk("R1 state disarmed", int'(st), 0);
    tick();
    chk("R1 sw bit disarmed", int'(brk), 0);
    tick();

    // R2/R4/R5: immediate route Stage1 -cmp0-> Stage2 -cmp1-> Final
    sel = {2'd3, 2'd1, 2'd0}; nxt = {3'd0, 3'd4, 3'd2};
    brk_en = 1; trace_en = 1;
    arm = 1; tick();
    chk("R4 idle to stage1", int'(st), 1);
    match = 4'b0001; tick(); match = 0;
    chk("R2 forced advance", int'(st), 2);
    match = 4'b0010; tick(); match = 0;
    chk("R5 brk on final", int'(brk), 1);
    chk("R5 trace on final", int'(trace), 1);
    chk("R4 final", int'(st), 4);
    tick();
    chk("R5 brk single pulse", int'(brk), 0);
    chk("R9 flag set", int'(flag), 1);

    // R9: disarm keeps flag, re-arm clears it
    arm = 0; tick();
    chk("R1 disarm idle", int'(st), 0);
    chk("R9 flag held", int'(flag), 1);
    tick();
    arm = 1; tick();
    chk("R9 flag cleared", int'(flag), 0);

    // R3: deferred comparator 2 routes Stage1 to Final
    defer = 4'b0100; sel = {2'd3, 2'd1, 2'd2}; nxt = {3'd0, 3'd4, 3'd4};
    match = 4'b0100; tick(); match = 0;
    chk("R3 match only marks", int'(st), 1);
    flush_p = 1; tick(); flush_p = 0;
    exec_p = 1; tick(); exec_p = 0;
    chk("R3 flushed mark dropped", int'(st), 1);
    match = 4'b0100; tick(); match = 0;
    tick();
    chk("R3 waits for exec", int'(st), 1);
    exec_p = 1; flush_p = 1; tick(); exec_p = 0; flush_p = 0;
    chk("R3 exec fires", int'(st), 4);
    chk("R3 brk on exec", int'(brk), 1);
    tick();

    // R6: secure mode blocks trace only
    arm = 0; tick(); secure = 1; defer = 0;
    arm = 1; tick();
    match = 4'b0100; tick(); match = 0;
    chk("R6 brk in secure", int'(brk), 1);
    chk("R6 no trace in secure", int'(trace), 0);
    secure = 0; tick();

    // R7/R8: bypass sources in Final
    ext_tag = 2'b10; tick(); ext_tag = 0;
    chk("R7 ext tag brk", int'(brk), 1);
    tick();
    chk("R7 ext tag released", int'(brk), 0);
    cop = 1; tick(); cop = 0;
    chk("R7 cop brk", int'(brk), 1);
    tick();
    sw_wr = 1; tick(); sw_wr = 0;
    chk("R8 sw bit set", int'(swt), 1);
    chk("R8 no brk yet", int'(brk), 0);
    tick();
    chk("R8 sw bit cleared", int'(swt), 0);
    chk("R8 brk follows", int'(brk), 1);
    tick();
    chk("R8 brk done", int'(brk), 0);

    // R4: code above 4 reaches Final, brk disabled; code 0 loops to Idle
    arm = 0; tick();
    brk_en = 0; sel = {2'd1, 2'd0, 2'd0}; nxt = {3'd7, 3'd0, 3'd3};
    arm = 1; tick();
    match = 4'b0001; tick(); match = 0;
    chk("R4 stage1 to stage3", int'(st), 3);
    match = 4'b0010; tick(); match = 0;
    chk("R4 code 7 is final", int'(st), 4);
    chk("R5 brk disabled", int'(brk), 0);
    chk("R5 trace enabled", int'(trace), 1);
    arm = 0; tick();
    nxt = {3'd7, 3'd0, 3'd0};
    arm = 1; tick();
    match = 4'b0001; tick(); match = 0;
    chk("R4 code 0 to idle", int'(st), 0);
    tick();
    chk("R4 idle re-enters stage1", int'(st), 1);
    tick(2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule